// File: doc/BRIEF.md
# Serial Loss-of-Signal Monitor with Reference Select

This block sits beside a clock-recovery loop and runs on the recovered bit clock. It picks one of two serial inputs. The primary line is used in normal operation; an active-low loopback control swaps in the loopback line. The chosen bit is registered and presented as the data output. An active-low external loss indication from the optical front end forces the primary data to zero and pulls lock-detect low at once. While loopback is selected, the external indication is ignored.

Loss is declared in two ways. The first is a run-length timeout on missing transitions. The second is a separate, shorter timer that runs while the external loss input is held. On a loss, the reference-select output moves the recovery loop onto the local reference. Loss clears only when two conditions hold at a 64-bit window boundary: the external indication is inactive, and the window saw enough transitions. A free-running phase counter supplies the 16-bit tick for both timers, the 64-bit window and a recovered-clock-divided-by-eight reference tick.

Top module: `rx_signal_watch`

## Requirements
- R1: While reset is held, `ref_local` is 1, `lock_ok` is 0 and `data_bit` is 0.
- R2: With `loop_en_n`=1 and `ext_los_n`=1, `data_bit` equals `prim_bit` from the previous clock.
- R3: With `loop_en_n`=0, `data_bit` equals `loop_bit` from the previous clock for either level of `ext_los_n`. A low `ext_los_n` then neither pulls `lock_ok` low nor blocks recovery.
- R4: With `loop_en_n`=1 and `ext_los_n`=0, `data_bit` is 0 from the next clock on, whatever `prim_bit` does, and `lock_ok` is 0 from the next clock on.
- R5: Once the selected data stops toggling, `ref_local` rises and `lock_ok` falls no sooner than 96 and no later than 114 clocks after the last transition is presented.
- R6: After `ext_los_n` falls, with loopback off, `ref_local` rises between 64 and 128 clocks later.
- R7: With the external loss inactive, data carrying at least 8 transitions in every 64-bit window clears a loss: `ref_local` drops to 0 and `lock_ok` rises to 1 within 192 clocks.
- R8: Data that toggles only once every 16 clocks (4 transitions per 64-bit window) neither clears an existing loss nor triggers the run-length timeout.
- R9: `ref_tick` is a single-clock pulse that repeats every 8 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered bit clock |
| rst_n | input | 1 | Synchronous reset, active low |
| prim_bit | input | 1 | Primary serial data |
| loop_bit | input | 1 | Loopback serial data |
| loop_en_n | input | 1 | Loopback select, active low |
| ext_los_n | input | 1 | External loss indication, active low |
| data_bit | output | 1 | Selected, squelched data, registered |
| ref_local | output | 1 | 1 = recovery loop follows the local reference |
| lock_ok | output | 1 | Lock-detect indication |
| ref_tick | output | 1 | Backup reference pulse, one clock every 8 |

## Verification
A stuck or mis-cleared run-length counter shows up at `ref_local` as a rise outside the 96–114 clock window, or as no rise at all. A transition detector that misses edges fires the timeout during sparse data. A density counter that saturates too early lets sparse data clear a loss, and this is visible within two windows, about 128 clocks. A wrong input-select or squelch path corrupts `data_bit` on the very next clock, and the scoreboard catches that bit for bit. A phase counter fault breaks the 8-clock `ref_tick` spacing within one period.

// File: rtl/los_pkg.sv
// Package: shared constants and types for the loss-of-signal monitor.
// Assumes: all timing constants are in recovered bit-clock periods.
package los_pkg;
    // log2 of the coarse tick period used by both loss timers
    localparam int unsigned TICK_LOG2   = 4;
    // log2 of the transition-density window
    localparam int unsigned WIN_LOG2    = 6;
    // log2 of the backup reference division ratio
    localparam int unsigned DIV_LOG2    = 3;
    // ticks of silence before loss is declared
    localparam int unsigned QUIET_TICKS = 7;
    // ticks of held external loss before the reference moves
    localparam int unsigned FORCE_TICKS = 5;
    // transitions per window that count as good data
    localparam int unsigned GOOD_EDGES  = 8;

    typedef enum logic {
        LINK_UP   = 1'b0,
        LINK_DOWN = 1'b1
    } link_state_e;
endpackage

// File: rtl/los_input_sel.sv
// Module: picks primary or loopback data, applies the external squelch,
// registers the chosen bit and flags a transition on the bit being loaded.
// Assumes: inputs are already in the recovered clock domain.
module los_input_sel (
    input  logic clk,
    input  logic rst_n,
    input  logic prim_bit,
    input  logic loop_bit,
    input  logic loop_en_n,
    input  logic ext_los_n,
    output logic data_q,
    output logic trans,
    output logic forced_q
);
    logic pick;
    logic forced_now;

    // Choose the live source; squelch primary data on external loss
    always_comb begin
        forced_now = loop_en_n & ~ext_los_n;
        if (!loop_en_n)
            pick = loop_bit;
        else if (ext_los_n)
            pick = prim_bit;
        else
            pick = 1'b0;
        trans = pick ^ data_q;
    end

    // Register the selected bit and the forced-loss condition
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q   <= 1'b0;
            forced_q <= 1'b0;
        end else begin
            data_q   <= pick;
            forced_q <= forced_now;
        end
    end
endmodule

// File: rtl/los_timebase.sv
// Module: free-running phase counter giving the coarse timer tick, the
// density window boundary and the divided backup reference tick.
// Assumes: TICK_LOG2 and DIV_LOG2 do not exceed WIN_LOG2.
module los_timebase #(
    parameter int unsigned WIN_LOG2  = 6,
    parameter int unsigned TICK_LOG2 = 4,
    parameter int unsigned DIV_LOG2  = 3
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick,
    output logic win_end,
    output logic div_tick
);
    logic [WIN_LOG2-1:0] phase;

    // Advance the shared phase every bit clock
    always_ff @(posedge clk) begin
        if (!rst_n)
            phase <= '0;
        else
            phase <= phase + 1'b1;
    end

    // Decode the three periodic strobes from the phase
    generate
        if (DIV_LOG2 == 0) begin : g_div_bypass
            assign div_tick = 1'b1;
        end else begin : g_div_decode
            assign div_tick = &phase[DIV_LOG2-1:0];
        end
    endgenerate

    always_comb begin
        tick    = &phase[TICK_LOG2-1:0];
        win_end = &phase;
    end
endmodule

// File: rtl/los_tick_timer.sv
// Module: saturating tick counter; expired once LIMIT ticks have passed
// without a clear. Clear wins over a tick in the same cycle.
// Assumes: LIMIT is at least 1.
module los_tick_timer #(
    parameter int unsigned LIMIT = 7,
    localparam int unsigned CW   = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic tick,
    output logic expired
);
    logic [CW-1:0] cnt;

    // Count ticks up to the limit, restart on clear
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (clear)
            cnt <= '0;
        else if (tick && (cnt != CW'(LIMIT)))
            cnt <= cnt + 1'b1;
    end

    // Flag that the limit has been reached
    always_comb expired = (cnt == CW'(LIMIT));
endmodule

// File: rtl/los_density.sv
// Module: counts transitions in each window and flags good data at the
// window boundary when at least EDGE_MIN were seen with no squelch.
// Assumes: win_end is a single-cycle strobe once per window.
module los_density #(
    parameter int unsigned EDGE_MIN = 8,
    localparam int unsigned CW      = $clog2(EDGE_MIN + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trans,
    input  logic squelch,
    input  logic win_end,
    output logic good
);
    logic [CW-1:0] cnt;
    logic [CW-1:0] nxt;
    logic          tainted;

    // Saturating next count including this cycle's transition
    always_comb begin
        nxt  = (trans && (cnt != CW'(EDGE_MIN))) ? cnt + 1'b1 : cnt;
        good = win_end && !squelch && !tainted && (nxt == CW'(EDGE_MIN));
    end

    // Accumulate per window; a squelch anywhere in the window spoils it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            tainted <= 1'b1;
        end else if (win_end) begin
            cnt     <= '0;
            tainted <= squelch;
        end else begin
            cnt     <= squelch ? '0 : nxt;
            tainted <= tainted | squelch;
        end
    end
endmodule

// File: rtl/rx_signal_watch.sv
// Module: top of the loss-of-signal monitor. It combines the run-length
// timeout, the forced-loss timer and the density check into one link state.
// That state drives the reference select and lock detect.
// Assumes: clocked by the recovered bit clock; reset is synchronous.
module rx_signal_watch
    import los_pkg::*;
#(
    parameter int unsigned P_TICK_LOG2   = TICK_LOG2,
    parameter int unsigned P_WIN_LOG2    = WIN_LOG2,
    parameter int unsigned P_DIV_LOG2    = DIV_LOG2,
    parameter int unsigned P_QUIET_TICKS = QUIET_TICKS,
    parameter int unsigned P_FORCE_TICKS = FORCE_TICKS,
    parameter int unsigned P_GOOD_EDGES  = GOOD_EDGES
) (
    input  logic clk,
    input  logic rst_n,
    input  logic prim_bit,
    input  logic loop_bit,
    input  logic loop_en_n,
    input  logic ext_los_n,
    output logic data_bit,
    output logic ref_local,
    output logic lock_ok,
    output logic ref_tick
);
    logic        data_q;
    logic        trans;
    logic        forced_q;
    logic        tick;
    logic        win_end;
    logic        div_tick;
    logic        quiet_exp;
    logic        force_exp;
    logic        good;
    link_state_e link_st;

    los_input_sel i_sel (
        .clk       (clk),
        .rst_n     (rst_n),
        .prim_bit  (prim_bit),
        .loop_bit  (loop_bit),
        .loop_en_n (loop_en_n),
        .ext_los_n (ext_los_n),
        .data_q    (data_q),
        .trans     (trans),
        .forced_q  (forced_q)
    );

    los_timebase #(
        .WIN_LOG2  (P_WIN_LOG2),
        .TICK_LOG2 (P_TICK_LOG2),
        .DIV_LOG2  (P_DIV_LOG2)
    ) i_tb (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .win_end  (win_end),
        .div_tick (div_tick)
    );

    // Run-length timeout: restarted by every transition
    los_tick_timer #(.LIMIT(P_QUIET_TICKS)) i_quiet (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (trans),
        .tick    (tick),
        .expired (quiet_exp)
    );

    // Forced-loss timer: runs only while the external loss is held
    los_tick_timer #(.LIMIT(P_FORCE_TICKS)) i_force (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (!forced_q),
        .tick    (tick),
        .expired (force_exp)
    );

    los_density #(.EDGE_MIN(P_GOOD_EDGES)) i_dens (
        .clk     (clk),
        .rst_n   (rst_n),
        .trans   (trans),
        .squelch (forced_q),
        .win_end (win_end),
        .good    (good)
    );

    // Link state: declaring loss has priority over clearing it
    always_ff @(posedge clk) begin
        if (!rst_n)
            link_st <= LINK_DOWN;
        else if (quiet_exp || force_exp)
            link_st <= LINK_DOWN;
        else if (good)
            link_st <= LINK_UP;
    end

    // Drive the outputs from the registered state
    always_comb begin
        data_bit  = data_q;
        ref_local = (link_st == LINK_DOWN);
        lock_ok   = (link_st == LINK_UP) && !forced_q;
        ref_tick  = div_tick;
    end
endmodule

// File: rtl/rx_signal_watch_chk.sv
// Module: property checker for rx_signal_watch, attached by bind.
// Assumes: observes only the top-level ports.
module rx_signal_watch_chk #(
    parameter int unsigned P_DIV_LOG2 = los_pkg::DIV_LOG2
) (
    input logic clk,
    input logic rst_n,
    input logic prim_bit,
    input logic loop_bit,
    input logic loop_en_n,
    input logic ext_los_n,
    input logic data_bit,
    input logic ref_local,
    input logic lock_ok,
    input logic ref_tick
);
    logic [P_DIV_LOG2-1:0] gap;
    logic                  seen;

    // Track clocks since the last reference tick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap  <= '0;
            seen <= 1'b0;
        end else if (ref_tick) begin
            gap  <= '0;
            seen <= 1'b1;
        end else begin
            gap  <= gap + 1'b1;
        end
    end

    assert_primary_path_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (loop_en_n && ext_los_n) |=> (data_bit == $past(prim_bit)));

    assert_loop_path_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !loop_en_n |=> (data_bit == $past(loop_bit)));

    assert_squelch_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (loop_en_n && !ext_los_n) |=> !data_bit);

    assert_squelch_lock_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (loop_en_n && !ext_los_n) |=> !lock_ok);

    assert_lock_vs_ref_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ref_local |-> !lock_ok);

    assert_tick_width_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ref_tick |=> !ref_tick);

    assert_tick_spacing_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_tick && seen) |-> (&gap));
endmodule

bind rx_signal_watch rx_signal_watch_chk #(.P_DIV_LOG2(P_DIV_LOG2)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .prim_bit  (prim_bit),
    .loop_bit  (loop_bit),
    .loop_en_n (loop_en_n),
    .ext_los_n (ext_los_n),
    .data_bit  (data_bit),
    .ref_local (ref_local),
    .lock_ok   (lock_ok),
    .ref_tick  (ref_tick)
);

// File: tb/test_rx_signal_watch.sv
module test_rx_signal_watch;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic prim_bit = 1'b0;
    logic loop_bit = 1'b0;
    logic loop_en_n = 1'b1;
    logic ext_los_n = 1'b1;
    logic data_bit, ref_local, lock_ok, ref_tick;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    bit done = 1'b0;

    typedef struct {
        logic  exp;
        string req;
    } sb_item_t;
    sb_item_t sbq[$];

    always #10 clk = ~clk;

    rx_signal_watch i_rx_signal_watch (
        .clk       (clk),
        .rst_n     (rst_n),
        .prim_bit  (prim_bit),
        .loop_bit  (loop_bit),
        .loop_en_n (loop_en_n),
        .ext_los_n (ext_los_n),
        .data_bit  (data_bit),
        .ref_local (ref_local),
        .lock_ok   (lock_ok),
        .ref_tick  (ref_tick)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic chk_range(input string req, input int act, input int lo, input int hi);
        checks++;
        if (act < lo || act > hi) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
        end
    endtask

    // Driver: apply one bit pair and push the value the requirements predict
    task automatic send_bit(input logic pb, input logic lb, input string req);
        sb_item_t it;
        @(negedge clk);
        prim_bit = pb;
        loop_bit = lb;
        if (!loop_en_n)      it.exp = lb;
        else if (ext_los_n)  it.exp = pb;
        else                 it.exp = 1'b0;
        it.req = req;
        sbq.push_back(it);
    endtask

    // Monitor: pop one expectation per clock once the register has loaded
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sbq.size() > 0) begin
                sb_item_t it;
                it = sbq.pop_front();
                chk(it.req, int'(data_bit), int'(it.exp));
            end
        end
    end

    // Count clocks until ref_local reads 1, capped
    task automatic wait_loss(input int cap, output int n);
        n = 0;
        while (ref_local !== 1'b1 && n < cap) begin
            @(posedge clk);
            #2;
            n++;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog: actual %0d expected below %0d cycles", cycles, 150000);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        int n;
        int pulses;
        int dbl;
        logic prev;

        // R1: reset state
        idle(3);
        chk("R1 ref_local", int'(ref_local), 1);
        chk("R1 lock_ok", int'(lock_ok), 0);
        chk("R1 data_bit", int'(data_bit), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R9: 8 single-clock pulses in 64 clocks
        pulses = 0; dbl = 0; prev = 1'b0;
        for (int i = 0; i < 64; i++) begin
            @(negedge clk);
            if (ref_tick) pulses++;
            if (ref_tick && prev) dbl++;
            prev = ref_tick;
        end
        chk("R9 pulse count", pulses, 8);
        chk("R9 back-to-back", dbl, 0);

        // R2 + R7: dense primary data clears the reset loss
        for (int i = 0; i < 200; i++) begin
            logic [7:0] v;
            v = 8'(i);
            send_bit(v[0] ^ v[3], ~v[1], "R2");
        end
        idle(2);
        chk("R7 ref_local after dense", int'(ref_local), 0);
        chk("R7 lock_ok after dense", int'(lock_ok), 1);

        // R5: silence (last bit was 1 at i=199)
        wait_loss(400, n);
        chk_range("R5 quiet timeout", n, 96, 114);
        chk("R5 lock_ok after timeout", int'(lock_ok), 0);

        // R8: sparse toggles neither clear loss
        for (int i = 0; i < 320; i++) begin
            logic [7:0] v;
            v = 8'(i);
            send_bit(v[4], 1'b0, "R2");
        end
        idle(2);
        chk("R8 sparse keeps loss", int'(ref_local), 1);

        // recover, then R8: sparse must not trip the timeout
        for (int i = 0; i < 200; i++) send_bit(i[0], 1'b0, "R2");
        idle(2);
        chk("R7 recovered", int'(ref_local), 0);
        for (int i = 0; i < 320; i++) begin
            logic [7:0] v;
            v = 8'(i);
            send_bit(v[4], 1'b0, "R2");
        end
        chk("R8 no timeout on sparse", int'(ref_local), 0);
        for (int i = 0; i < 200; i++) send_bit(i[0], 1'b0, "R2");
        idle(2);
        chk("R7 still up", int'(ref_local), 0);

        // R4 + R6: forced loss
        @(negedge clk);
        ext_los_n = 1'b0;
        @(posedge clk);
        #2;
        chk("R4 lock_ok forced low", int'(lock_ok), 0);
        chk("R4 data_bit squelched", int'(data_bit), 0);
        wait_loss(300, n);
        chk_range("R6 forced switch", n + 1, 64, 128);
        // toggling under squelch: data stays 0 and loss holds (R4, R7)
        for (int i = 0; i < 200; i++) send_bit(i[0], 1'b0, "R4");
        idle(2);
        chk("R7 loss held while forced", int'(ref_local), 1);
        chk("R4 lock_ok while forced", int'(lock_ok), 0);
        @(negedge clk);
        ext_los_n = 1'b1;
        for (int i = 0; i < 200; i++) send_bit(i[0], 1'b0, "R2");
        idle(2);
        chk("R7 recovery after release", int'(ref_local), 0);
        chk("R7 lock_ok after release", int'(lock_ok), 1);

        // R3: loopback with external loss held low is unaffected
        @(negedge clk);
        loop_en_n = 1'b0;
        ext_los_n = 1'b0;
        for (int i = 0; i < 200; i++) begin
            logic [7:0] v;
            v = 8'(i);
            send_bit(1'b1, v[0] ^ v[2], "R3");
        end
        idle(2);
        chk("R3 lock_ok ignores ext loss", int'(lock_ok), 1);
        chk("R3 ref_local ignores ext loss", int'(ref_local), 0);

        idle(4);
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule